// File: doc/BRIEF.md
# Mouse Motion Packet Queue

This block converts one pointing-device motion event into a fixed five-byte packet and stores the packet in a byte queue that a host drains one byte per read strobe. An event carries a signed horizontal delta, a signed vertical delta and the state of three buttons. The block builds a header byte with the button states active low, limits both deltas to the signed range -127..+127 (the vertical delta is negated first), and appends two zero bytes.

The queue holds 256 bytes, wraps its read and write pointers, and throws away any byte that arrives while it is full. A data-available output is high whenever at least one byte is stored, so after every read it stays high if more bytes remain. The encoder takes a new event only when it is idle. It then writes the five bytes on five consecutive cycles and holds its busy output high during those cycles.

Top module: `mouse_packet_queue`

## Requirements
- R1: The first byte of a packet is 0x87 with bit 2 cleared when the left button is pressed (ev_btn[2]), bit 1 cleared for the middle button (ev_btn[1]) and bit 0 cleared for the right button (ev_btn[0]).
- R2: The second byte is the horizontal delta limited to -127..+127, as 8-bit two's complement. Values above 127 give 0x7F and values below -127 give 0x81.
- R3: The third byte is the negated vertical delta, limited to -127..+127 in the same way as R2.
- R4: The fourth and fifth bytes are always 0x00. The five bytes are read back in the order header, horizontal, vertical, zero, zero.
- R5: The queue stores at most 256 bytes. A byte produced while 256 bytes are stored is discarded, and the stored bytes are not changed.
- R6: A read strobe while the queue is empty returns 0x00 on rd_data and changes no state.
- R7: An event is accepted only when busy is low. busy is high on exactly the five cycles after acceptance, and ev_valid while busy is ignored.
- R8: data_avail is high exactly when one or more bytes are stored. It therefore stays high after a read that leaves bytes behind and falls after the read that removes the last byte.
- R9: Bytes come out in the order they were stored, across packet boundaries and across pointer wrap-around. rd_data shows the oldest byte in the same cycle as rd_stb, and the byte is removed at that clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Motion event present |
| ev_dx | input | 10 | Horizontal delta, signed |
| ev_dy | input | 10 | Vertical delta, signed |
| ev_btn | input | 3 | Buttons pressed: [2] left, [1] middle, [0] right |
| busy | output | 1 | Encoder is writing a packet |
| rd_stb | input | 1 | Single-cycle read strobe |
| rd_data | output | 8 | Oldest stored byte, or 0x00 when empty |
| data_avail | output | 1 | At least one byte is stored |

## Verification
Bad occupancy state shows up at the ports in one of two ways: data_avail switches at the wrong read, or a read on an empty queue returns a stale byte instead of zero. Both are visible within one packet of the fault. Pointer faults reorder or repeat bytes, and this shows on the next read. Faults that only appear at wrap-around show after at most 256 further bytes. Each of these is exposed by reading every byte back against an arithmetic model, through a sweep of boundary deltas and every button combination, and then a fill past capacity.

// File: rtl/mouse_packet_queue.sv
module mouse_packet_queue #(
  parameter int IW = 10,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  input  logic [IW-1:0] ev_dx,
  input  logic [IW-1:0] ev_dy,
  input  logic [2:0]    ev_btn,
  output logic          busy,
  input  logic          rd_stb,
  output logic [7:0]    rd_data,
  output logic          data_avail
);
  localparam int DEPTH = 1 << AW;

  function automatic logic [7:0] sat8(input logic signed [IW:0] v);
    if (v > 127)       return 8'h7F;
    else if (v < -127) return 8'h81;
    else               return v[7:0];
  endfunction

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt;
  logic [2:0]    step;
  logic [7:0]    hdr_q, dx_q, dy_q, wbyte;
  logic          full, do_wr, do_rd, accept;
  logic signed [IW:0] dx_ext, dy_neg;

  assign dx_ext = {ev_dx[IW-1], ev_dx};
  assign dy_neg = -$signed({ev_dy[IW-1], ev_dy});
  assign accept = ev_valid && !busy;
  assign full   = (cnt == DEPTH[AW:0]);
  assign do_wr  = busy && !full;
  assign do_rd  = rd_stb && data_avail;
  assign data_avail = (cnt != '0);
  assign rd_data = data_avail ? mem[rptr] : 8'h00;

  always_comb begin
    case (step)
      3'd0:    wbyte = hdr_q;
      3'd1:    wbyte = dx_q;
      3'd2:    wbyte = dy_q;
      default: wbyte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      step  <= '0;
      hdr_q <= '0;
      dx_q  <= '0;
      dy_q  <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      step  <= '0;
      hdr_q <= 8'h87 & ~{5'b0, ev_btn};
      dx_q  <= sat8(dx_ext);
      dy_q  <= sat8(dy_neg);
    end else if (busy) begin
      step <= step + 3'd1;
      if (step == 3'd4) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk)
    if (do_wr) mem[wptr] <= wbyte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) rptr <= rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= DEPTH[AW:0]);
  assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_stb) |=> $stable(wptr));
  assert_empty_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !data_avail && !busy) |=> ($stable(rptr) && !data_avail));
  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step != 3'd4) |=> busy);
  assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step == 3'd4) |=> !busy);
  assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step != 3'd4) |=> ($stable(hdr_q) && $stable(dx_q) && $stable(dy_q)));
  assert_avail_after_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && !rd_stb) |=> data_avail);
  assert_header_form_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step == 3'd0) |-> (wbyte[7:3] == 5'b10000));
endmodule

// File: tb/mouse_packet_queue_tb.sv
module mouse_packet_queue_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, ev_valid = 1'b0, rd_stb = 1'b0;
  logic [9:0] ev_dx = '0, ev_dy = '0;
  logic [2:0] ev_btn = '0;
  logic busy, data_avail;
  logic [7:0] rd_data;
  int n_chk = 0, n_bad = 0;
  logic [7:0] mq[$];

  always #2.5 clk = ~clk;

  mouse_packet_queue dut_i (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_dx(ev_dx), .ev_dy(ev_dy),
    .ev_btn(ev_btn), .busy(busy), .rd_stb(rd_stb), .rd_data(rd_data),
    .data_avail(data_avail));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sat(input int v);
    if (v > 127) return 8'h7F;
    if (v < -127) return 8'h81;
    return v[7:0];
  endfunction

  function automatic void mpush(input logic [7:0] b);
    if (mq.size() < 256) mq.push_back(b);
  endfunction

  task automatic send(input int dx, input int dy, input int btn, input bit poke);
    int bc = 0;
    @(negedge clk);
    ev_dx = dx[9:0]; ev_dy = dy[9:0]; ev_btn = btn[2:0]; ev_valid = 1'b1;
    @(negedge clk);
    ev_valid = 1'b0;
    if (poke) begin
      ev_dx = 10'd5; ev_dy = 10'd5; ev_btn = 3'd7; ev_valid = 1'b1;
    end
    while (busy) begin
      bc++;
      @(negedge clk);
    end
    ev_valid = 1'b0;
    chk(bc == 5, "R7 busy cycles", bc, 5);
    mpush(8'h87 & ~btn[7:0]);
    mpush(sat(dx));
    mpush(sat(-dy));
    mpush(8'h00);
    mpush(8'h00);
    chk(data_avail == (mq.size() != 0), "R8 avail after packet", data_avail, mq.size() != 0);
  endtask

  task automatic rd_one(input string req);
    logic [7:0] e;
    @(negedge clk);
    rd_stb = 1'b1;
    #1;
    e = (mq.size() != 0) ? mq.pop_front() : 8'h00;
    chk(rd_data == e, req, rd_data, e);
    @(posedge clk);
    #1 rd_stb = 1'b0;
    @(negedge clk);
    chk(data_avail == (mq.size() != 0), "R8 avail after read", data_avail, mq.size() != 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int vals[11] = '{-512, -200, -128, -127, -1, 0, 1, 126, 127, 128, 511};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(busy == 0, "R7 reset busy", busy, 0);
    chk(data_avail == 0, "R8 reset avail", data_avail, 0);
    chk(rd_data == 0, "R6 reset data", rd_data, 0);
    rd_one("R6 empty read");
    // boundary deltas, all button codes: R1 R2 R3 R4 R9
    foreach (vals[i]) foreach (vals[j]) begin
      send(vals[i], vals[j], (i + j) % 8, 1'b0);
      for (int k = 0; k < 5; k++) rd_one("R1 R2 R3 R4 R9 packet byte");
    end
    // two packets queued before reading: R9 ordering
    send(3, -4, 5, 1'b0);
    send(-90, 300, 2, 1'b0);
    for (int k = 0; k < 10; k++) rd_one("R9 order");
    // events while busy are ignored: R7
    send(40, 40, 1, 1'b1);
    for (int k = 0; k < 5; k++) rd_one("R7 busy ignore byte");
    chk(data_avail == 0, "R7 no extra packet", data_avail, 0);
    rd_one("R6 empty after drain");
    // fill past capacity with wrapped pointers: R5 R9
    for (int e = 0; e < 52; e++) send(e * 7 - 180, 150 - e * 6, e % 8, 1'b0);
    chk(mq.size() == 256, "R5 model full", mq.size(), 256);
    for (int k = 0; k < 256; k++) rd_one("R5 R9 full drain");
    rd_one("R6 empty after full");
    rd_one("R6 empty again");
    // state unchanged by empty reads: next packet intact
    send(-127, 127, 4, 1'b0);
    for (int k = 0; k < 5; k++) rd_one("R6 post-empty packet");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule